// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the registers of a PCI message-signalled interrupt capability. It sits behind a dword-wide configuration access port with a byte address, write data, byte enables and a combinational read path. Three parameters fix its shape: 32-bit or 64-bit message address, per-vector masking present or absent, and the number of vectors the function supports (a power of two from 1 to 32). The register layout inside the capability window, and the window size itself, follow from those options.

Software programs the message address, the message data, the enable bit and the requested vector count through the port. Each field has its own write mask. A request for more vectors than the function supports is clamped whenever the enable bit is left set. The decoded fields go out on plain outputs to an interrupt dispatcher. The dispatcher, in turn, uses set and clear strobes to keep the pending bits up to date. Those bits are read-only from the configuration side.

Top module: `msi_cap_regs`

## Requirements
- R1: The dword at CAP_BASE reads capability ID 0x05 in bits [7:0], NEXT_PTR in [15:8] and the control word in [31:16]. In the control word, bit 16 is the enable bit, [19:17] is log2(NUM_VEC) (read-only), [22:20] is the requested vector log2, bit 23 is the 64-bit flag and bit 24 is the mask-capable flag. Only the enable bit and the requested log2 change on a write.
- R2: The window starts at CAP_BASE and is 0x0A, 0x0E, 0x14 or 0x18 bytes long, for 32-bit without mask, 64-bit without mask, 32-bit with mask and 64-bit with mask. Reads outside the window return zero, and writes outside it change nothing.
- R3: The low message address sits at +4 and its bits [1:0] read zero. In 64-bit mode the fully writable high address sits at +8 and the data sits at +0x0C. In 32-bit mode the data sits at +8. The data register is 16 bits, its upper half reads zero, and each byte enable gates one byte lane.
- R4: The mask register sits at +0x0C (32-bit) or +0x10 (64-bit). Only bits 0 to NUM_VEC-1 are writable, and the rest read zero.
- R5: Any in-window write that leaves the enable bit at 1 with a requested log2 above log2(NUM_VEC) stores log2(NUM_VEC) instead. With the enable bit at 0, the requested value is stored as written.
- R6: The pending register sits at +0x10 (32-bit) or +0x14 (64-bit) and ignores port writes. A bit of pend_set sets its pending bit and a bit of pend_clr clears it, one cycle later. Set wins when both strobes hit the same bit.
- R7: Any in-window write that leaves the enable bit at 1 drops every pending bit with index at or above 2^(requested log2 after clamping). This includes bits set by a strobe in the same cycle. No other event drops pending bits.
- R8: msi_en, vec_log2, msg_addr ({high, low}, high zero in 32-bit mode), msg_data, vec_mask and vec_pend follow the registers.
- R9: Reset clears the enable bit, the requested log2, both address registers, the data register, and the mask and pending registers.
- R10: Without the mask option there is no mask or pending register, vec_mask and vec_pend stay zero, and the strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | CFG_AW | Byte address of the dword accessed; bits [1:0] are ignored |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write lanes |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pend_set | input | NUM_VEC | Pending set strobes from the dispatcher |
| pend_clr | input | NUM_VEC | Pending clear strobes from the dispatcher |
| msi_en | output | 1 | Enable bit |
| vec_log2 | output | 3 | Requested vector log2 |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | NUM_VEC | Per-vector mask bits |
| vec_pend | output | NUM_VEC | Per-vector pending bits |

## Verification
A configuration write that enables the function with a smaller vector count can land in the same cycle as a dispatcher set strobe. In that case the pending drop has to apply to the freshly set bits as well as to the old ones. The bench provokes this by writing the control byte with enable at 1 and a log2 of 1 while strobing bits 0 and 6. It then expects only bits 0 and 1 to survive. A same-cycle set and clear on one bit is also driven, and set is expected to win.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

   localparam logic [7:0] CAP_ID = 8'h05;

   typedef enum logic [2:0] {
      FS_NONE,
      FS_HDR,
      FS_ALO,
      FS_AHI,
      FS_DATA,
      FS_MASK,
      FS_PEND
   } fsel_e;

   // window length in bytes for the chosen options
   function automatic int unsigned cap_bytes(input bit a64, input bit msk);
      if (a64) return msk ? 32'h18 : 32'h0E;
      return msk ? 32'h14 : 32'h0A;
   endfunction

   // field living in dword dw of the window
   function automatic fsel_e dw_field(input bit a64, input bit msk, input int unsigned dw);
      case (dw)
         0: return FS_HDR;
         1: return FS_ALO;
         2: return a64 ? FS_AHI : FS_DATA;
         3: return a64 ? FS_DATA : (msk ? FS_MASK : FS_NONE);
         4: return msk ? (a64 ? FS_MASK : FS_PEND) : FS_NONE;
         5: return (a64 && msk) ? FS_PEND : FS_NONE;
         default: return FS_NONE;
      endcase
   endfunction

   // replace the byte lanes selected by be
   function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                             input logic [31:0] wd,
                                             input logic [3:0]  be);
      logic [31:0] r;
      r = old;
      for (int b = 0; b < 4; b++)
         if (be[b]) r[8*b +: 8] = wd[8*b +: 8];
      return r;
   endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
   import msi_cap_pkg::*;
#(
   parameter int unsigned CFG_AW   = 12,
   parameter int unsigned CAP_BASE = 'h50,
   parameter bit          ADDR64   = 1'b1,
   parameter bit          MASK_EN  = 1'b1
) (
   input  logic [CFG_AW-1:0] addr,
   output logic              in_win,
   output fsel_e             sel
);
   localparam logic [CFG_AW-1:0] BASE_L = CFG_AW'(CAP_BASE);
   localparam logic [CFG_AW-1:0] SIZE_L = CFG_AW'(cap_bytes(ADDR64, MASK_EN));

   logic [CFG_AW-1:0] rel;

   always_comb begin
      rel    = addr - BASE_L;
      in_win = (addr >= BASE_L) && (rel < SIZE_L);
      sel    = in_win ? dw_field(ADDR64, MASK_EN, 32'(rel[CFG_AW-1:2])) : FS_NONE;
   end
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
   parameter int unsigned NUM_VEC = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_any,
   input  logic       wr_ctl,
   input  logic [7:0] ctl_byte,
   output logic       en,
   output logic [2:0] mme,
   output logic [2:0] mme_nxt,
   output logic       drop
);
   localparam logic [2:0] MMC_L = 3'($clog2(NUM_VEC));

   logic       en_q, en_w;
   logic [2:0] mme_q, mme_w;

   always_comb begin
      en_w  = en_q;
      mme_w = mme_q;
      if (wr_ctl) begin
         en_w  = ctl_byte[0];
         mme_w = ctl_byte[6:4];
      end
      if (wr_any && en_w && (mme_w > MMC_L))
         mme_w = MMC_L;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         mme_q <= 3'd0;
      end else begin
         en_q  <= en_w;
         mme_q <= mme_w;
      end
   end

   assign en      = en_q;
   assign mme     = mme_q;
   assign mme_nxt = mme_w;
   assign drop    = wr_any && en_w;
endmodule

// File: rtl/msi_cap_vecbits.sv
module msi_cap_vecbits
   import msi_cap_pkg::*;
#(
   parameter int unsigned NUM_VEC = 8,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_mask,
   input  logic [31:0]        wdata,
   input  logic [3:0]         be,
   input  logic [NUM_VEC-1:0] set_s,
   input  logic [NUM_VEC-1:0] clr_s,
   input  logic               drop,
   input  logic [2:0]         mme_nxt,
   output logic [NUM_VEC-1:0] mask,
   output logic [NUM_VEC-1:0] pend
);
   generate
      if (MASK_EN) begin : g_vec
         logic [NUM_VEC-1:0] mask_q, pend_q, pend_d, keep;
         logic [31:0]        mask_m;

         for (genvar i = 0; i < NUM_VEC; i++) begin : g_keep
            assign keep[i] = ((i >> mme_nxt) == 0);
         end

         always_comb begin
            mask_m = lane_merge(32'(mask_q), wdata, be);
            pend_d = (pend_q & ~clr_s) | set_s;
            if (drop) pend_d = pend_d & keep;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask_q <= '0;
               pend_q <= '0;
            end else begin
               if (wr_mask) mask_q <= mask_m[NUM_VEC-1:0];
               pend_q <= pend_d;
            end
         end

         assign mask = mask_q;
         assign pend = pend_q;
      end else begin : g_novec
         logic unused_vec;
         assign unused_vec = ^{clk, rst_n, wr_mask, wdata, be, set_s, clr_s, drop, mme_nxt};
         assign mask = '0;
         assign pend = '0;
      end
   endgenerate
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
   import msi_cap_pkg::*;
#(
   parameter int unsigned CFG_AW   = 12,
   parameter int unsigned CAP_BASE = 'h50,
   parameter logic [7:0]  NEXT_PTR = 8'h00,
   parameter bit          ADDR64   = 1'b1,
   parameter bit          MASK_EN  = 1'b1,
   parameter int unsigned NUM_VEC  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CFG_AW-1:0]  cfg_addr,
   input  logic               cfg_wr,
   input  logic [31:0]        cfg_wdata,
   input  logic [3:0]         cfg_be,
   output logic [31:0]        cfg_rdata,
   input  logic [NUM_VEC-1:0] pend_set,
   input  logic [NUM_VEC-1:0] pend_clr,
   output logic               msi_en,
   output logic [2:0]         vec_log2,
   output logic [63:0]        msg_addr,
   output logic [15:0]        msg_data,
   output logic [NUM_VEC-1:0] vec_mask,
   output logic [NUM_VEC-1:0] vec_pend
);
   localparam logic [2:0] MMC_L = 3'($clog2(NUM_VEC));

   logic        in_win, wr_any, drop, en;
   fsel_e       sel;
   logic [2:0]  mme, mme_nxt;
   logic [29:0] alo_q;
   logic [31:0] ahi;
   logic [15:0] data_q;
   logic [31:0] alo_m, data_m;
   logic [15:0] ctl16;

   msi_cap_decode #(
      .CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE), .ADDR64(ADDR64), .MASK_EN(MASK_EN)
   ) u_dec (
      .addr(cfg_addr), .in_win(in_win), .sel(sel)
   );

   assign wr_any = cfg_wr && in_win;

   msi_cap_ctrl #(.NUM_VEC(NUM_VEC)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_any(wr_any),
      .wr_ctl(wr_any && (sel == FS_HDR) && cfg_be[2]),
      .ctl_byte(cfg_wdata[23:16]),
      .en(en), .mme(mme), .mme_nxt(mme_nxt), .drop(drop)
   );

   msi_cap_vecbits #(.NUM_VEC(NUM_VEC), .MASK_EN(MASK_EN)) u_vec (
      .clk(clk), .rst_n(rst_n),
      .wr_mask(wr_any && (sel == FS_MASK)),
      .wdata(cfg_wdata), .be(cfg_be),
      .set_s(pend_set), .clr_s(pend_clr),
      .drop(drop), .mme_nxt(mme_nxt),
      .mask(vec_mask), .pend(vec_pend)
   );

   // low address and data registers
   always_comb begin
      alo_m  = lane_merge({alo_q, 2'b00}, cfg_wdata, cfg_be);
      data_m = lane_merge({16'h0000, data_q}, cfg_wdata, cfg_be);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alo_q  <= '0;
         data_q <= '0;
      end else begin
         if (wr_any && (sel == FS_ALO))  alo_q  <= alo_m[31:2];
         if (wr_any && (sel == FS_DATA)) data_q <= data_m[15:0];
      end
   end

   // high address only for the 64-bit layout
   generate
      if (ADDR64) begin : g_ahi
         logic [31:0] ahi_q;
         logic [31:0] ahi_m;
         assign ahi_m = lane_merge(ahi_q, cfg_wdata, cfg_be);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           ahi_q <= '0;
            else if (wr_any && (sel == FS_AHI))   ahi_q <= ahi_m;
         end
         assign ahi = ahi_q;
      end else begin : g_noahi
         assign ahi = '0;
      end
   endgenerate

   assign ctl16 = {7'b0, MASK_EN, ADDR64, mme, MMC_L, en};

   always_comb begin
      case (sel)
         FS_HDR:  cfg_rdata = {ctl16, NEXT_PTR, CAP_ID};
         FS_ALO:  cfg_rdata = {alo_q, 2'b00};
         FS_AHI:  cfg_rdata = ahi;
         FS_DATA: cfg_rdata = {16'h0000, data_q};
         FS_MASK: cfg_rdata = 32'(vec_mask);
         FS_PEND: cfg_rdata = 32'(vec_pend);
         default: cfg_rdata = '0;
      endcase
   end

   assign msi_en   = en;
   assign vec_log2 = mme;
   assign msg_addr = {ahi, alo_q, 2'b00};
   assign msg_data = data_q;
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk
   import msi_cap_pkg::*;
#(
   parameter int unsigned CFG_AW   = 12,
   parameter int unsigned CAP_BASE = 'h50,
   parameter bit          ADDR64   = 1'b1,
   parameter bit          MASK_EN  = 1'b1,
   parameter int unsigned NUM_VEC  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CFG_AW-1:0]  cfg_addr,
   input logic               cfg_wr,
   input logic [31:0]        cfg_rdata,
   input logic [NUM_VEC-1:0] pend_set,
   input logic [NUM_VEC-1:0] pend_clr,
   input logic               msi_en,
   input logic [2:0]         vec_log2,
   input logic [63:0]        msg_addr,
   input logic [15:0]        msg_data,
   input logic [NUM_VEC-1:0] vec_mask,
   input logic [NUM_VEC-1:0] vec_pend
);
   localparam logic [CFG_AW-1:0] BASE_L = CFG_AW'(CAP_BASE);
   localparam logic [CFG_AW-1:0] SIZE_L = CFG_AW'(cap_bytes(ADDR64, MASK_EN));
   localparam logic [2:0]        MMC_L  = 3'($clog2(NUM_VEC));

   initial begin
      if (NUM_VEC < 1 || NUM_VEC > 32 || (NUM_VEC & (NUM_VEC - 1)) != 0)
         $fatal(1, "NUM_VEC must be a power of two from 1 to 32");
      if ((CAP_BASE % 4) != 0 || CAP_BASE + 32'h18 > (32'd1 << CFG_AW))
         $fatal(1, "CAP_BASE must be dword aligned and fit the address space");
   end

   logic [CFG_AW-1:0] rel;
   logic              in_win, wr_in;
   assign rel    = cfg_addr - BASE_L;
   assign in_win = (cfg_addr >= BASE_L) && (rel < SIZE_L);
   assign wr_in  = cfg_wr && in_win;

   AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> (cfg_rdata == 32'h0)); // R2

   AST_OUTSIDE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !in_win) |=> ($stable(msi_en) && $stable(vec_log2) && $stable(msg_addr)
                               && $stable(msg_data) && $stable(vec_mask))); // R2

   AST_EN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      msi_en |-> (vec_log2 <= MMC_L)); // R5

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (MASK_EN && (|pend_set) && !wr_in) |=>
         ((vec_pend & $past(pend_set)) == $past(pend_set))); // R6

   AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_clr & ~pend_set)) |=> ((vec_pend & $past(pend_clr & ~pend_set)) == '0)); // R6

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_in && (pend_set == '0) && (pend_clr == '0)) |=> $stable(vec_pend)); // R6

   AST_PEND_DROP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_in |=> (!msi_en || ((32'(vec_pend) >> (6'd1 << vec_log2)) == 32'h0))); // R7

endmodule

bind msi_cap_regs msi_cap_chk #(
   .CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE), .ADDR64(ADDR64),
   .MASK_EN(MASK_EN), .NUM_VEC(NUM_VEC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
   .cfg_rdata(cfg_rdata), .pend_set(pend_set), .pend_clr(pend_clr),
   .msi_en(msi_en), .vec_log2(vec_log2), .msg_addr(msg_addr),
   .msg_data(msg_data), .vec_mask(vec_mask), .vec_pend(vec_pend)
);

// File: tb/sim_msi_cap_regs.sv
module sim_msi_cap_regs;
   localparam int CLK_P = 10;
   localparam int NT    = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [3:0]  cfg_be = '0;
   logic [7:0]  pend_set = '0, pend_clr = '0;
   logic [31:0] rdata, rdata1;
   logic        msi_en, msi_en1;
   logic [2:0]  vec_log2, vec_log2_1;
   logic [63:0] msg_addr, msg_addr1;
   logic [15:0] msg_data, msg_data1;
   logic [7:0]  vec_mask, vec_pend;
   logic [0:0]  vec_mask1, vec_pend1;
   int nchk = 0, nerr = 0;

   always #(CLK_P/2) clk = ~clk;

   // 64-bit with mask, 8 vectors
   msi_cap_regs #(.CFG_AW(12), .CAP_BASE('h50), .NEXT_PTR(8'h70),
                  .ADDR64(1'b1), .MASK_EN(1'b1), .NUM_VEC(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(rdata),
      .pend_set(pend_set), .pend_clr(pend_clr), .msi_en(msi_en),
      .vec_log2(vec_log2), .msg_addr(msg_addr), .msg_data(msg_data),
      .vec_mask(vec_mask), .vec_pend(vec_pend));

   // 32-bit without mask, 1 vector
   msi_cap_regs #(.CFG_AW(12), .CAP_BASE('h50), .NEXT_PTR(8'h00),
                  .ADDR64(1'b0), .MASK_EN(1'b0), .NUM_VEC(1)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(rdata1),
      .pend_set(pend_set[0:0]), .pend_clr(pend_clr[0:0]), .msi_en(msi_en1),
      .vec_log2(vec_log2_1), .msg_addr(msg_addr1), .msg_data(msg_data1),
      .vec_mask(vec_mask1), .vec_pend(vec_pend1));

   // {write, addr[11:0], wdata[31:0], be[3:0], expected read[31:0], tag[15:0]}
   localparam logic [96:0] TBL [NT] = '{
      {1'b1, 12'h054, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_FFFC, "R3"},
      {1'b1, 12'h058, 32'h1234_5678, 4'hF, 32'h1234_5678, "R3"},
      {1'b1, 12'h05C, 32'hABCD_BEEF, 4'hF, 32'h0000_BEEF, "R3"},
      {1'b1, 12'h054, 32'h0000_00AA, 4'h1, 32'hFFFF_FFA8, "R3"},
      {1'b1, 12'h060, 32'hFFFF_FFFF, 4'hF, 32'h0000_00FF, "R4"},
      {1'b1, 12'h064, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, "R6"},
      {1'b1, 12'h050, 32'hFFFF_FFFF, 4'hF, 32'h01B7_7005, "R5"},
      {1'b1, 12'h050, 32'h0000_0000, 4'hC, 32'h0186_7005, "R1"},
      {1'b1, 12'h050, 32'h0020_0000, 4'h4, 32'h01A6_7005, "R1"},
      {1'b1, 12'h050, 32'h0060_0000, 4'h4, 32'h01E6_7005, "R5"},
      {1'b1, 12'h050, 32'h0051_0000, 4'h4, 32'h01B7_7005, "R5"},
      {1'b1, 12'h068, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, "R2"},
      {1'b1, 12'h04C, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, "R2"},
      {1'b1, 12'h050, 32'hFF30_0000, 4'hC, 32'h01B6_7005, "R1"},
      {1'b0, 12'h070, 32'h0000_0000, 4'h0, 32'h0000_0000, "R2"}
   };

   task automatic chk(input logic [15:0] tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be,
                     input logic [7:0] s = 8'h00, input logic [7:0] c = 8'h00);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
      pend_set = s; pend_clr = c;
      @(negedge clk);
      cfg_wr = 1'b0; pend_set = '0; pend_clr = '0;
   endtask

   task automatic strobe(input logic [7:0] s, input logic [7:0] c);
      @(negedge clk);
      pend_set = s; pend_clr = c;
      @(negedge clk);
      pend_set = '0; pend_clr = '0;
   endtask

   task automatic rd0(input logic [15:0] tag, input logic [11:0] a, input logic [31:0] exp);
      cfg_addr = a; #1;
      chk(tag, 64'(rdata), 64'(exp));
   endtask

   task automatic rd1(input logic [15:0] tag, input logic [11:0] a, input logic [31:0] exp);
      cfg_addr = a; #1;
      chk(tag, 64'(rdata1), 64'(exp));
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      #(CLK_P * 100000);
      nerr++;
      $display("FAIL watchdog act=running exp=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: values straight after reset
      chk("R9", 64'({msi_en, vec_log2, vec_mask, vec_pend}), 64'h0);
      chk("R9", msg_addr, 64'h0);
      rd0("R1", 12'h050, 32'h0186_7005);
      rst_n = 1'b1;

      for (int i = 0; i < NT; i++) begin
         if (TBL[i][96]) wr(TBL[i][95:84], TBL[i][83:52], TBL[i][51:48]);
         rd0(TBL[i][15:0], TBL[i][95:84], TBL[i][47:16]);
      end
      rd0("R2", 12'h054, 32'hFFFF_FFA8);

      // R8: exported fields
      chk("R8", 64'({msi_en, vec_log2}), 64'h3);
      chk("R8", msg_addr, 64'h1234_5678_FFFF_FFA8);
      chk("R8", 64'(msg_data), 64'hBEEF);
      chk("R8", 64'(vec_mask), 64'hFF);

      // R6: dispatcher strobes
      strobe(8'h05, 8'h00);
      chk("R6", 64'(vec_pend), 64'h05);
      rd0("R6", 12'h064, 32'h0000_0005);
      strobe(8'h00, 8'h01);
      chk("R6", 64'(vec_pend), 64'h04);
      strobe(8'h02, 8'h06);
      chk("R6", 64'(vec_pend), 64'h02);
      strobe(8'h84, 8'h00);
      chk("R6", 64'(vec_pend), 64'h86);

      // R7: enable with 2 vectors while strobing bits 0 and 6 in the same cycle
      wr(12'h050, 32'h0011_0000, 4'h4, 8'h41, 8'h00);
      chk("R7", 64'(vec_pend), 64'h03);
      chk("R8", 64'({msi_en, vec_log2}), 64'h9);
      strobe(8'h10, 8'h00);
      chk("R7", 64'(vec_pend), 64'h13);
      wr(12'h068, 32'h0000_0000, 4'hF);
      chk("R7", 64'(vec_pend), 64'h13);
      wr(12'h05C, 32'h0000_1111, 4'h3);
      chk("R7", 64'(vec_pend), 64'h03);
      chk("R3", 64'(msg_data), 64'h1111);
      wr(12'h050, 32'h0000_0000, 4'h4);
      strobe(8'h80, 8'h00);
      wr(12'h05C, 32'h0000_2222, 4'h3);
      chk("R7", 64'(vec_pend), 64'h83);

      // R9: reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R9", 64'({msi_en, vec_log2, vec_mask, vec_pend}), 64'h0);
      chk("R9", msg_addr, 64'h0);
      chk("R9", 64'(msg_data), 64'h0);
      rd0("R9", 12'h050, 32'h0186_7005);
      @(negedge clk); rst_n = 1'b1;

      // R10: 32-bit layout without mask
      rd1("R10", 12'h050, 32'h0000_0005);
      wr(12'h050, 32'h0021_0000, 4'h4);
      rd1("R5", 12'h050, 32'h0001_0005);
      wr(12'h058, 32'h0000_1234, 4'hF);
      chk("R3", 64'(msg_data1), 64'h1234);
      rd1("R2", 12'h05C, 32'h0000_0000);
      wr(12'h054, 32'hFFFF_FFFF, 4'hF);
      chk("R3", msg_addr1, 64'h0000_0000_FFFF_FFFC);
      strobe(8'h01, 8'h00);
      chk("R10", 64'({vec_mask1, vec_pend1}), 64'h0);

      summary();
   end
endmodule